// File: doc/BRIEF.md
# Software Write-Protect Command Detector

This block sits in front of the page-write engines of a byte-addressed flash card with several segments. Every byte write to the card passes through it. The low bits of the card address pick the segment. Each segment has its own detector, which watches the writes that reach it for fixed address/data command tokens. A three-token command turns software protection on and opens one page-write window. A six-token command turns protection off.

While protection is on, a segment forwards a write only if the write falls inside the window that a just-completed enable command opened. Command tokens are never forwarded as data. A write that breaks a partly matched command sends that segment's matcher back to idle and raises a sequence-error pulse. The breaking write is then judged as an ordinary write.

Top module: `swp_guard`

## Requirements
- R1: After reset every bit of `prot_on` equals the parameter `PROT_RESET`, and `wr_allow` and `seq_err` are all zero.
- R2: Card address bits [SEL_W-1:0] (SEL_W = log2 NSEG) select the segment, and the remaining upper bits form the segment address. A write affects only the selected segment's outputs.
- R3: A strobe that is neither a command token nor a window write, on an unprotected segment, raises that segment's `wr_allow` bit for exactly the one cycle after the strobe edge.
- R4: On a protected segment, an ordinary write outside a window leaves `wr_allow` low.
- R5: The enable command is data 0xAA at segment address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. Completing it sets `prot_on` and opens a window. No command token write raises `wr_allow`. `prot_on` changes only on a strobe edge.
- R6: A window write is accepted if it is captured at most `WINDOW_CYC` cycles after the arming write or after the previous accepted window write. A write captured later is judged as an ordinary write.
- R7: A window closes after `PAGE_BYTES` accepted writes. The next write is judged as an ordinary write.
- R8: The disable command is 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. It clears `prot_on` and opens no window.
- R9: A write that mismatches the expected token after at least one token has matched pulses `seq_err` for one cycle and returns the matcher to idle. That write is judged as an ordinary write and does not start a new match.
- R10: Only the low `CMD_AW` (15) bits of the segment address are compared with the command addresses. Higher bits are ignored.
- R11: Segments hold separate protection states and separate matchers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle byte write strobe |
| wr_addr | input | CARD_AW | Card byte address, low bits select the segment |
| wr_data | input | 8 | Write data byte |
| prot_on | output | NSEG | Protection state per segment |
| wr_allow | output | NSEG | Per-segment pulse: the previous cycle's write may be programmed |
| seq_err | output | NSEG | Per-segment pulse: the previous cycle's write broke a command |

## Verification
Two events can fall in the same cycle: a window running out and a new strobe arriving. The window timer reaches zero on exactly the edge where a late page byte is captured. The bench arms a window and delays the next byte by `WINDOW_CYC` cycles, which is accepted, and then delays another byte by one cycle more, which must be blocked while protection stays on. A second clash, a page-limit closure against the next back-to-back byte, is provoked with a four-byte page and judged at the fifth write.

// File: rtl/swp_pkg.sv
package swp_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_T1   = 3'd1,
      ST_T2   = 3'd2,
      ST_T3   = 3'd3,
      ST_T4   = 3'd4,
      ST_T5   = 3'd5
   } step_t;

   localparam logic [7:0]  TK_LEAD  = 8'hAA;
   localparam logic [7:0]  TK_SECND = 8'h55;
   localparam logic [7:0]  TK_ARM   = 8'hA0;
   localparam logic [7:0]  TK_EXT   = 8'h80;
   localparam logic [7:0]  TK_OFF   = 8'h20;
   localparam logic [14:0] CA_ODD   = 15'h5555;
   localparam logic [14:0] CA_EVEN  = 15'h2AAA;
   localparam int          TOKEN_AW = 15;

   typedef struct packed {
      logic hit;
      logic done_en;
      logic done_dis;
   } match_t;
endpackage

// File: rtl/swp_token_match.sv
module swp_token_match
   import swp_pkg::*;
#(
   parameter int CMD_AW = 15
) (
   input  step_t             step,
   input  logic [CMD_AW-1:0] cmd_addr,
   input  logic [7:0]        data,
   output match_t            m
);
   logic [CMD_AW-1:0] exp_addr;
   logic              addr_ok;
   logic              data_ok;

   always_comb begin
      if (step == ST_T1 || step == ST_T4) exp_addr = CMD_AW'(CA_EVEN);
      else                                exp_addr = CMD_AW'(CA_ODD);
      addr_ok = (cmd_addr == exp_addr);
      case (step)
         ST_IDLE, ST_T3: data_ok = (data == TK_LEAD);
         ST_T1, ST_T4:   data_ok = (data == TK_SECND);
         ST_T2:          data_ok = (data == TK_ARM) || (data == TK_EXT);
         ST_T5:          data_ok = (data == TK_OFF);
         default:        data_ok = 1'b0;
      endcase
      m.hit      = addr_ok && data_ok;
      m.done_en  = addr_ok && (step == ST_T2) && (data == TK_ARM);
      m.done_dis = addr_ok && (step == ST_T5) && (data == TK_OFF);
   end
endmodule

// File: rtl/swp_window.sv
module swp_window #(
   parameter int WINDOW_CYC = 37500,
   parameter int PAGE_BYTES = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic take,
   output logic open
);
   localparam int TW = $clog2(WINDOW_CYC + 1);
   localparam int CW = (PAGE_BYTES > 2) ? $clog2(PAGE_BYTES) : 1;

   logic [TW-1:0] timer;
   logic [CW-1:0] cnt;

   assign open = (timer != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         timer <= '0;
         cnt   <= '0;
      end else if (arm) begin
         timer <= TW'(WINDOW_CYC);
         cnt   <= '0;
      end else if (take) begin
         if (cnt == CW'(PAGE_BYTES - 1)) begin
            timer <= '0;
            cnt   <= '0;
         end else begin
            timer <= TW'(WINDOW_CYC);
            cnt   <= cnt + CW'(1);
         end
      end else if (open) begin
         timer <= timer - TW'(1);
      end
   end
endmodule

// File: rtl/swp_seg.sv
module swp_seg
   import swp_pkg::*;
#(
   parameter int SEG_AW     = 17,
   parameter int CMD_AW     = 15,
   parameter int WINDOW_CYC = 37500,
   parameter int PAGE_BYTES = 256,
   parameter bit PROT_RESET = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb,
   input  logic [SEG_AW-1:0] addr,
   input  logic [7:0]        data,
   output logic              prot,
   output logic              allow,
   output logic              err
);
   step_t  step;
   match_t m;
   logic   win_open;
   logic   arm;
   logic   take;

   swp_token_match #(.CMD_AW(CMD_AW)) u_match (
      .step     (step),
      .cmd_addr (addr[CMD_AW-1:0]),
      .data     (data),
      .m        (m)
   );

   assign take = stb && win_open;
   assign arm  = stb && !win_open && m.done_en;

   swp_window #(.WINDOW_CYC(WINDOW_CYC), .PAGE_BYTES(PAGE_BYTES)) u_win (
      .clk  (clk),
      .rst_n(rst_n),
      .arm  (arm),
      .take (take),
      .open (win_open)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step  <= ST_IDLE;
         prot  <= PROT_RESET;
         allow <= 1'b0;
         err   <= 1'b0;
      end else begin
         allow <= 1'b0;
         err   <= 1'b0;
         if (stb) begin
            if (win_open) begin
               allow <= 1'b1;
               step  <= ST_IDLE;
            end else if (m.hit) begin
               if (m.done_en) begin
                  prot <= 1'b1;
                  step <= ST_IDLE;
               end else if (m.done_dis) begin
                  prot <= 1'b0;
                  step <= ST_IDLE;
               end else begin
                  step <= step_t'(step + 3'd1);
               end
            end else begin
               allow <= !prot;
               err   <= (step != ST_IDLE);
               step  <= ST_IDLE;
            end
         end
      end
   end
endmodule

// File: rtl/swp_guard.sv
module swp_guard #(
   parameter int NSEG       = 2,
   parameter int CARD_AW    = 18,
   parameter int CMD_AW     = 15,
   parameter int WINDOW_CYC = 37500,
   parameter int PAGE_BYTES = 256,
   parameter bit PROT_RESET = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_stb,
   input  logic [CARD_AW-1:0] wr_addr,
   input  logic [7:0]         wr_data,
   output logic [NSEG-1:0]    prot_on,
   output logic [NSEG-1:0]    wr_allow,
   output logic [NSEG-1:0]    seq_err
);
   localparam int SEL_W  = (NSEG > 2) ? $clog2(NSEG) : 1;
   localparam int SEG_AW = CARD_AW - SEL_W;

   if (NSEG < 2 || (1 << SEL_W) != NSEG) begin : g_bad_nseg
      $error("NSEG must be a power of two of at least 2");
   end
   if (CMD_AW < swp_pkg::TOKEN_AW || CMD_AW > SEG_AW) begin : g_bad_cmd
      $error("CMD_AW must lie between the token width and the segment address width");
   end
   if (WINDOW_CYC < 1 || PAGE_BYTES < 2) begin : g_bad_win
      $error("WINDOW_CYC must be at least 1 and PAGE_BYTES at least 2");
   end

   logic [SEL_W-1:0]  sel;
   logic [SEG_AW-1:0] seg_addr;

   assign sel      = wr_addr[SEL_W-1:0];
   assign seg_addr = wr_addr[CARD_AW-1:SEL_W];

   for (genvar g = 0; g < NSEG; g++) begin : g_seg
      swp_seg #(
         .SEG_AW    (SEG_AW),
         .CMD_AW    (CMD_AW),
         .WINDOW_CYC(WINDOW_CYC),
         .PAGE_BYTES(PAGE_BYTES),
         .PROT_RESET(PROT_RESET)
      ) u_seg (
         .clk  (clk),
         .rst_n(rst_n),
         .stb  (wr_stb && (sel == SEL_W'(g))),
         .addr (seg_addr),
         .data (wr_data),
         .prot (prot_on[g]),
         .allow(wr_allow[g]),
         .err  (seq_err[g])
      );
   end
endmodule

// File: rtl/swp_guard_chk.sv
module swp_guard_chk #(
   parameter int NSEG = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr_stb,
   input logic [7:0]      wr_data,
   input logic [NSEG-1:0] prot_on,
   input logic [NSEG-1:0] wr_allow,
   input logic [NSEG-1:0] seq_err
);
   a_r3_allow_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_allow != '0) |-> $past(wr_stb));

   a_r2_one_segment_acts: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_allow | seq_err));

   a_r5_prot_moves_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(prot_on) |-> $past(wr_stb));

   a_r9_err_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_err != '0) |-> $past(wr_stb));

   for (genvar g = 0; g < NSEG; g++) begin : g_chk
      a_r5_rise_on_arm_token: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(prot_on[g]) |-> ($past(wr_data) == 8'hA0));

      a_r8_fall_on_off_token: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(prot_on[g]) |-> ($past(wr_data) == 8'h20));

      a_r4_err_allow_only_unprot: assert property (@(posedge clk) disable iff (!rst_n)
         (seq_err[g] && wr_allow[g]) |-> !prot_on[g]);
   end
endmodule

bind swp_guard swp_guard_chk #(.NSEG(NSEG)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_stb  (wr_stb),
   .wr_data (wr_data),
   .prot_on (prot_on),
   .wr_allow(wr_allow),
   .seq_err (seq_err)
);

// File: tb/sim_swp_guard.sv
module sim_swp_guard;
   localparam int W  = 8;
   localparam int PG = 4;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_stb;
   logic [17:0] wr_addr;
   logic [7:0]  wr_data;
   logic [1:0]  prot_on, wr_allow, seq_err;

   always #2 clk = ~clk;

   swp_guard #(.NSEG(2), .CARD_AW(18), .CMD_AW(15), .WINDOW_CYC(W),
               .PAGE_BYTES(PG), .PROT_RESET(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
      .wr_data(wr_data), .prot_on(prot_on), .wr_allow(wr_allow), .seq_err(seq_err));

   typedef struct {
      logic [1:0] allow;
      logic [1:0] err;
      logic [1:0] prot;
      string      tag;
   } exp_t;

   exp_t       sb[$];
   int         n_cmp = 0;
   int         n_bad = 0;
   logic [1:0] ep = 2'b00;
   logic       seen = 1'b0;
   bit         done = 1'b0;

   task automatic wr(input int seg, input logic [16:0] a, input logic [7:0] d,
                     input bit al, input bit er, input string tag);
      exp_t e;
      e.allow = al ? (2'b01 << seg) : 2'b00;
      e.err   = er ? (2'b01 << seg) : 2'b00;
      e.prot  = ep;
      e.tag   = tag;
      wr_stb  = 1'b1;
      wr_addr = {a, seg[0]};
      wr_data = d;
      sb.push_back(e);
      @(negedge clk);
      wr_stb = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic enable_seq(input int seg, input logic [16:0] hi, input logic [16:0] lo,
                             input logic [1:0] prot_after, input string tag);
      wr(seg, hi, 8'hAA, 0, 0, tag);
      wr(seg, lo, 8'h55, 0, 0, tag);
      ep = prot_after;
      wr(seg, hi, 8'hA0, 0, 0, tag);
   endtask

   always @(posedge clk) seen <= wr_stb;

   always @(negedge clk) begin
      if (seen) begin
         n_cmp++;
         if (sb.size() == 0) begin
            n_bad++;
            $display("FAIL scoreboard empty: actual allow=%b err=%b expected an item", wr_allow, seq_err);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (wr_allow !== e.allow || seq_err !== e.err || prot_on !== e.prot) begin
               n_bad++;
               $display("FAIL %s: actual allow=%b err=%b prot=%b expected allow=%b err=%b prot=%b",
                        e.tag, wr_allow, seq_err, prot_on, e.allow, e.err, e.prot);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; wr_stb = 1'b0; wr_addr = '0; wr_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      n_cmp++;
      if (prot_on !== 2'b00 || wr_allow !== 2'b00 || seq_err !== 2'b00) begin
         n_bad++;
         $display("FAIL R1: actual prot=%b allow=%b err=%b expected 00 00 00", prot_on, wr_allow, seq_err);
      end

      wr(0, 17'h00100, 8'h12, 1, 0, "R3 unprotected write");
      enable_seq(0, 17'h05555, 17'h02AAA, 2'b01, "R5 enable tokens seg0");
      for (int i = 0; i < PG; i++) wr(0, 17'h00200 + 17'(i), 8'h40, 1, 0, "R7 page byte inside window");
      wr(0, 17'h00204, 8'h41, 0, 0, "R7 byte beyond page limit");
      wr(0, 17'h00300, 8'h42, 0, 0, "R4 protected write blocked");
      wr(1, 17'h00300, 8'h43, 1, 0, "R11 other segment unaffected");

      enable_seq(0, 17'h05555, 17'h02AAA, 2'b01, "R5 re-enable seg0");
      idle(W - 1);
      wr(0, 17'h00500, 8'h44, 1, 0, "R6 write at last window cycle");
      idle(W);
      wr(0, 17'h00501, 8'h45, 0, 0, "R6 write one cycle after expiry");

      wr(0, 17'h05555, 8'hAA, 0, 0, "R9 step0");
      wr(0, 17'h01234, 8'h55, 0, 1, "R9 wrong address at step1");
      wr(0, 17'h05555, 8'hAA, 0, 0, "R9 step0");
      wr(0, 17'h02AAA, 8'h56, 0, 1, "R9 wrong data at step1");
      wr(0, 17'h05555, 8'hAA, 0, 0, "R9 step0");
      wr(0, 17'h02AAA, 8'h55, 0, 0, "R9 step1");
      wr(0, 17'h05555, 8'hA1, 0, 1, "R9 wrong data at step2");
      wr(0, 17'h05555, 8'hAA, 0, 0, "R9 step0");
      wr(0, 17'h05555, 8'hAA, 0, 1, "R9 repeated lead breaks step1");
      wr(0, 17'h02AAA, 8'h55, 0, 0, "R9 no rematch after break");
      wr(0, 17'h05555, 8'hA0, 0, 0, "R9 no arm after break");
      wr(0, 17'h00400, 8'h46, 0, 0, "R9 still blocked");
      wr(0, 17'h05555, 8'hAA, 0, 0, "R9 dis step0");
      wr(0, 17'h02AAA, 8'h55, 0, 0, "R9 dis step1");
      wr(0, 17'h05555, 8'h80, 0, 0, "R9 dis step2");
      wr(0, 17'h05555, 8'hAA, 0, 0, "R9 dis step3");
      wr(0, 17'h02AAA, 8'h55, 0, 0, "R9 dis step4");
      wr(0, 17'h05555, 8'h21, 0, 1, "R9 wrong data at step5");

      wr(0, 17'h05555, 8'hAA, 0, 0, "R8 disable");
      wr(0, 17'h02AAA, 8'h55, 0, 0, "R8 disable");
      wr(0, 17'h05555, 8'h80, 0, 0, "R8 disable");
      wr(0, 17'h05555, 8'hAA, 0, 0, "R8 disable");
      wr(0, 17'h02AAA, 8'h55, 0, 0, "R8 disable");
      ep = 2'b00;
      wr(0, 17'h05555, 8'h20, 0, 0, "R8 disable last token");
      wr(0, 17'h00600, 8'h47, 1, 0, "R8 ordinary write after disable");

      enable_seq(1, 17'h15555, 17'h12AAA, 2'b10, "R10 seg1 enable upper bits ignored");
      idle(W + 2);
      wr(1, 17'h00700, 8'h48, 0, 0, "R2 seg1 protected write");
      wr(0, 17'h00700, 8'h49, 1, 0, "R11 seg0 still unprotected");

      wr(0, 17'h05555, 8'hAA, 0, 0, "R5 command token not forwarded");
      wr(0, 17'h00010, 8'h33, 1, 1, "R9 break judged ordinary unprotected");

      wr(1, 17'h05555, 8'hAA, 0, 0, "R8 seg1 disable");
      wr(1, 17'h02AAA, 8'h55, 0, 0, "R8 seg1 disable");
      wr(1, 17'h05555, 8'h80, 0, 0, "R8 seg1 disable");
      wr(1, 17'h05555, 8'hAA, 0, 0, "R8 seg1 disable");
      wr(1, 17'h02AAA, 8'h55, 0, 0, "R8 seg1 disable");
      ep = 2'b00;
      wr(1, 17'h05555, 8'h20, 0, 0, "R8 seg1 disable last");
      wr(1, 17'h00800, 8'h4A, 1, 0, "R3 seg1 write after disable");

      idle(3);
      n_cmp++;
      if (sb.size() != 0) begin
         n_bad++;
         $display("FAIL R3 scoreboard drain: actual %0d left expected 0", sb.size());
      end
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule